// File: doc/BRIEF.md
# Interrupt Message Queue with Register Readout

This block collects interrupt events that an upstream decoder has already classified. Each event is either a legacy wire-style interrupt (one of four lines, asserted or released) or a message-signalled interrupt that carries an address fragment and a 32-bit data word. The block stores the events in arrival order and shows the oldest one to software through two 32-bit registers on a simple register port.

Software reads the descriptor word first and the payload word after it. Neither read changes the queue. When software has finished with the oldest entry, it writes any value to either of the two registers, and that entry leaves the queue. A mode pin tells the block whether the device is acting as a root port. When it is not, both registers read as zero and writes to them do nothing.

The event input is a single-beat stream qualified by `ev_valid`. It has no ready signal and never applies back-pressure. An event that arrives while the queue is full and no entry leaves in the same cycle is dropped, and a sticky overflow flag is set.

Top module: `irq_msg_queue`

## Requirements
- R1: The descriptor register sits at offset 0x158. Its bits 15:0 hold the requester ID, bits 26:16 hold MSI address bits 12:2, bits 28:27 hold the line, bit 29 holds the assert flag, bit 30 holds the MSI flag and bit 31 holds valid. `reg_rdata` is zero whenever `reg_rd` is low, and it reflects the addressed register combinationally while `reg_rd` is high.
- R2: For a line event, bit 30 reads 0. The line field encodes A/B/C/D as 00/01/10/11. Bit 29 reads 1 for assert and 0 for release. The address field and the payload word read zero.
- R3: For an MSI event, bit 30 reads 1, bits 28:27 read 00 and bit 29 reads 0, whatever values arrived on the line inputs. The payload register at offset 0x15C returns the data word of the same head entry.
- R4: A read of either register leaves the head entry in place.
- R5: A write to offset 0x158 or 0x15C removes the head entry, and the written data is ignored. Writes to any other offset remove nothing.
- R6: Bit 31 reads 1 while the queue holds an entry. When the queue is empty, both registers read as all zeros.
- R7: On each rising clock edge where `ev_valid` is high, one event is taken in. Entries leave in arrival order, and the queue holds up to DEPTH (default 16) entries.
- R8: An event that arrives while the queue is full and no entry is removed in the same cycle is dropped. It also sets `overflow`, which then stays high until reset.
- R9: A removal request while the queue is empty has no effect.
- R10: An arrival and a removal in the same cycle both take effect. This holds even when the queue is full.
- R11: While `root_mode` is low, both registers read zero and writes to them remove nothing.
- R12: Reset empties the queue and clears `overflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_mode | input | 1 | High when the device acts as a root port |
| ev_valid | input | 1 | An event is presented this cycle |
| ev_is_msi | input | 1 | 1 = MSI event, 0 = line event |
| ev_line | input | 2 | Line select for line events |
| ev_assert | input | 1 | 1 = assert, 0 = release (line events) |
| ev_req_id | input | 16 | Requester ID |
| ev_msi_addr | input | 11 | MSI address bits 12:2 |
| ev_msi_data | input | 32 | MSI data word |
| reg_addr | input | 12 | Register byte offset |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data (ignored) |
| reg_rdata | output | 32 | Read data |
| overflow | output | 1 | Sticky: an event was dropped |

## Verification
The assertions check several properties on every cycle:
- the fill count never goes above the depth;
- an arrival at a full queue leaves the count unchanged and raises the flag;
- the flag never falls;
- a removal on an empty queue leaves the count at zero;
- a combined arrival and removal keeps the count;
- a descriptor read with valid low is all zeros;
- an MSI descriptor never shows line or assert bits;
- endpoint mode returns zero.

Other behaviours can only be shown by the bench's scenarios. These include arrival ordering across a full queue, the exact field placement for each line code, the payload matching its descriptor, and reads that leave the head in place. They also include the write data and unrelated offsets having no effect, and the head surviving a write made in endpoint mode.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;

  localparam int REQ_ID_W   = 16;
  localparam int MSI_ADDR_W = 11;
  localparam int MSI_DATA_W = 32;
  localparam int LINE_W     = 2;
  localparam int WORD_W     = 32;

  typedef enum logic [LINE_W-1:0] {
    LINE_A = 2'b00,
    LINE_B = 2'b01,
    LINE_C = 2'b10,
    LINE_D = 2'b11
  } line_e;

  typedef struct packed {
    logic                  is_msi;
    line_e                 line;
    logic                  asrt;
    logic [REQ_ID_W-1:0]   req_id;
    logic [MSI_ADDR_W-1:0] msi_addr;
    logic [MSI_DATA_W-1:0] msi_data;
  } irq_entry_t;

endpackage

// File: rtl/irq_event_pack.sv
module irq_event_pack
  import irq_msg_pkg::*;
(
  input  logic                  ev_is_msi,
  input  logic [LINE_W-1:0]     ev_line,
  input  logic                  ev_assert,
  input  logic [REQ_ID_W-1:0]   ev_req_id,
  input  logic [MSI_ADDR_W-1:0] ev_msi_addr,
  input  logic [MSI_DATA_W-1:0] ev_msi_data,
  output irq_entry_t            entry
);

  // Each kind keeps only the fields that belong to it; the rest are zeroed.
  always_comb begin
    entry.is_msi = ev_is_msi;
    entry.req_id = ev_req_id;
    if (ev_is_msi) begin
      entry.line     = LINE_A;
      entry.asrt     = 1'b0;
      entry.msi_addr = ev_msi_addr;
      entry.msi_data = ev_msi_data;
    end else begin
      entry.line     = line_e'(ev_line);
      entry.asrt     = ev_assert;
      entry.msi_addr = '0;
      entry.msi_data = '0;
    end
  end

endmodule

// File: rtl/irq_entry_fifo.sv
module irq_entry_fifo
  import irq_msg_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push_req,
  input  irq_entry_t push_entry,
  input  logic       pop_req,
  output irq_entry_t head,
  output logic       not_empty,
  output logic       ovf
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  irq_entry_t       mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             empty, full, do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty     = (count == '0);
  assign full      = (count == CNT_W'(DEPTH));
  assign do_pop    = pop_req && !empty;
  assign do_push   = push_req && (!full || do_pop);
  assign head      = mem[rd_ptr];
  assign not_empty = !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_entry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push_req && !do_push) ovf <= 1'b1;
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R7
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && full && !pop_req) |=> (count == $past(count)) && ovf); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf); // R8
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && empty && !push_req) |=> (count == '0)); // R9
  AST_PUSH_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && pop_req && !empty) |=> (count == $past(count))); // R10

endmodule

// File: rtl/irq_reg_view.sv
module irq_reg_view
  import irq_msg_pkg::*;
#(
  parameter int              ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] DESC_OFF = 12'h158,
  parameter logic [ADDR_W-1:0] DATA_OFF = 12'h15C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              root_mode,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  irq_entry_t        head,
  input  logic              head_valid,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              pop_req
);

  logic              hit_desc, hit_data;
  logic [WORD_W-1:0] desc_word;

  assign hit_desc = (reg_addr == DESC_OFF);
  assign hit_data = (reg_addr == DATA_OFF);

  // Field order here is the software-visible layout.
  assign desc_word = {head_valid, head.is_msi, head.asrt, head.line,
                      head.msi_addr, head.req_id};

  always_comb begin
    reg_rdata = '0;
    if (root_mode && reg_rd && head_valid) begin
      if (hit_desc)      reg_rdata = desc_word;
      else if (hit_data) reg_rdata = head.msi_data;
    end
  end

  assign pop_req = root_mode && reg_wr && (hit_desc || hit_data);

  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && hit_desc && !reg_rdata[31]) |-> (reg_rdata == '0)); // R6
  AST_MSI_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && hit_desc && reg_rdata[30]) |-> (reg_rdata[29:27] == 3'b000)); // R3
  AST_ENDPOINT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !root_mode |-> (reg_rdata == '0) && !pop_req); // R11

endmodule

// File: rtl/irq_msg_queue.sv
module irq_msg_queue
  import irq_msg_pkg::*;
#(
  parameter int                DEPTH    = 16,
  parameter int                ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] DESC_OFF = 12'h158,
  parameter logic [ADDR_W-1:0] DATA_OFF = 12'h15C
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  root_mode,
  input  logic                  ev_valid,
  input  logic                  ev_is_msi,
  input  logic [LINE_W-1:0]     ev_line,
  input  logic                  ev_assert,
  input  logic [REQ_ID_W-1:0]   ev_req_id,
  input  logic [MSI_ADDR_W-1:0] ev_msi_addr,
  input  logic [MSI_DATA_W-1:0] ev_msi_data,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic                  reg_rd,
  input  logic                  reg_wr,
  input  logic [WORD_W-1:0]     reg_wdata,
  output logic [WORD_W-1:0]     reg_rdata,
  output logic                  overflow
);

  irq_entry_t in_entry, head;
  logic       head_valid, pop_req;
  logic       unused_wdata;

  // Write data carries no meaning: any write to a queue register pops.
  assign unused_wdata = ^reg_wdata;

  irq_event_pack u_pack (
    .ev_is_msi   (ev_is_msi),
    .ev_line     (ev_line),
    .ev_assert   (ev_assert),
    .ev_req_id   (ev_req_id),
    .ev_msi_addr (ev_msi_addr),
    .ev_msi_data (ev_msi_data),
    .entry       (in_entry)
  );

  irq_entry_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_req   (ev_valid),
    .push_entry (in_entry),
    .pop_req    (pop_req),
    .head       (head),
    .not_empty  (head_valid),
    .ovf        (overflow)
  );

  irq_reg_view #(
    .ADDR_W   (ADDR_W),
    .DESC_OFF (DESC_OFF),
    .DATA_OFF (DATA_OFF)
  ) u_view (
    .clk        (clk),
    .rst_n      (rst_n),
    .root_mode  (root_mode),
    .reg_addr   (reg_addr),
    .reg_rd     (reg_rd),
    .reg_wr     (reg_wr),
    .head       (head),
    .head_valid (head_valid),
    .reg_rdata  (reg_rdata),
    .pop_req    (pop_req)
  );

endmodule

// File: tb/tb_irq_msg_queue.sv
module tb_irq_msg_queue;

  localparam logic [11:0] A_DESC = 12'h158;
  localparam logic [11:0] A_DATA = 12'h15C;

  logic        clk = 1'b0, rst_n = 1'b0, root_mode = 1'b1;
  logic        ev_valid = 0, ev_is_msi = 0, ev_assert = 0;
  logic [1:0]  ev_line = 0;
  logic [15:0] ev_req_id = 0;
  logic [10:0] ev_msi_addr = 0;
  logic [31:0] ev_msi_data = 0;
  logic [11:0] reg_addr = 0;
  logic        reg_rd = 0, reg_wr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        overflow;
  int          n_checks = 0, n_errors = 0;

  always #5 clk = ~clk;

  irq_msg_queue dut (
    .clk(clk), .rst_n(rst_n), .root_mode(root_mode),
    .ev_valid(ev_valid), .ev_is_msi(ev_is_msi), .ev_line(ev_line),
    .ev_assert(ev_assert), .ev_req_id(ev_req_id), .ev_msi_addr(ev_msi_addr),
    .ev_msi_data(ev_msi_data), .reg_addr(reg_addr), .reg_rd(reg_rd),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .overflow(overflow)
  );

  function automatic logic [31:0] exp_desc(input logic msi, input logic [1:0] ln,
      input logic as, input logic [15:0] rid, input logic [10:0] ad);
    return {1'b1, msi, msi ? 1'b0 : as, msi ? 2'b00 : ln, msi ? ad : 11'h0, rid};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic set_ev(input logic msi, input logic [1:0] ln, input logic as,
      input logic [15:0] rid, input logic [10:0] ad, input logic [31:0] d);
    ev_valid = 1; ev_is_msi = msi; ev_line = ln; ev_assert = as;
    ev_req_id = rid; ev_msi_addr = ad; ev_msi_data = d;
  endtask

  task automatic push(input logic msi, input logic [1:0] ln, input logic as,
      input logic [15:0] rid, input logic [10:0] ad, input logic [31:0] d);
    @(negedge clk);
    set_ev(msi, ln, as, rid, ad, d);
    @(negedge clk);
    ev_valid = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a; reg_rd = 1;
    #1 v = reg_rdata;
    reg_rd = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr = 1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic t_reset_state();
    logic [31:0] v;
    rd(A_DESC, v); chk("R6/R12 desc after reset", v, 32'h0);
    rd(A_DATA, v); chk("R6/R12 data after reset", v, 32'h0);
    chk("R12 overflow after reset", {31'h0, overflow}, 32'h0);
  endtask

  task automatic t_line_events();
    logic [31:0] v;
    push(0, 2'b10, 1, 16'h1234, 11'h7FF, 32'hDEAD_BEEF);
    push(0, 2'b00, 0, 16'hBEEF, 11'h123, 32'h1111_2222);
    push(0, 2'b11, 1, 16'h0001, 11'h0, 32'h0);
    rd(A_DESC, v); chk("R1/R2 line C assert", v, exp_desc(0, 2'b10, 1, 16'h1234, 0));
    chk("R1 field bits 28:27", {30'h0, v[28:27]}, 32'h2);
    rd(A_DATA, v); chk("R2 line payload zero", v, 32'h0);
    rd(A_DESC, v); chk("R4 reread keeps head", v, exp_desc(0, 2'b10, 1, 16'h1234, 0));
    rd(12'h000, v); chk("R1 other offset reads zero", v, 32'h0);
    wr(A_DESC, 32'hFFFF_FFFF);
    rd(A_DESC, v); chk("R2/R5 line A release", v, exp_desc(0, 2'b00, 0, 16'hBEEF, 0));
    wr(A_DATA, 32'h0);
    rd(A_DESC, v); chk("R2/R5 line D assert", v, 32'hB800_0001);
    wr(A_DESC, 32'h5);
    rd(A_DESC, v); chk("R6 empty desc", v, 32'h0);
  endtask

  task automatic t_msi();
    logic [31:0] v;
    push(1, 2'b11, 1, 16'h00AB, 11'h5A5, 32'hCAFE_F00D);
    rd(A_DESC, v); chk("R3 msi desc", v, exp_desc(1, 0, 0, 16'h00AB, 11'h5A5));
    chk("R3 msi flag bit", {31'h0, v[30]}, 32'h1);
    rd(A_DATA, v); chk("R3 msi payload", v, 32'hCAFE_F00D);
    wr(12'h160, 32'h0);
    wr(12'h15A, 32'h0);
    rd(A_DATA, v); chk("R5 unrelated write keeps head", v, 32'hCAFE_F00D);
    wr(A_DATA, 32'h1234_5678);
    rd(A_DATA, v); chk("R5/R6 empty payload", v, 32'h0);
  endtask

  task automatic t_order_overflow();
    logic [31:0] v;
    chk("R8 overflow low before fill", {31'h0, overflow}, 32'h0);
    for (int i = 0; i < 16; i++) push(0, 2'(i), i[0], 16'(16'h100 + i), 0, 0);
    chk("R8 overflow low at exactly full", {31'h0, overflow}, 32'h0);
    push(0, 2'b01, 1, 16'hAAAA, 0, 0);
    chk("R8 overflow set on drop", {31'h0, overflow}, 32'h1);
    for (int i = 0; i < 16; i++) begin
      rd(A_DESC, v);
      chk("R7 arrival order", v, exp_desc(0, 2'(i), i[0], 16'(16'h100 + i), 0));
      wr(A_DESC, 0);
    end
    rd(A_DESC, v); chk("R8 dropped event absent", v, 32'h0);
    chk("R8 overflow sticky", {31'h0, overflow}, 32'h1);
  endtask

  task automatic t_empty_pop();
    logic [31:0] v;
    wr(A_DESC, 0);
    wr(A_DATA, 0);
    push(1, 0, 0, 16'h0777, 11'h001, 32'h0000_0042);
    rd(A_DATA, v); chk("R9 pop on empty ignored", v, 32'h0000_0042);
    wr(A_DESC, 0);
    rd(A_DESC, v); chk("R9 single entry drained", v, 32'h0);
  endtask

  task automatic t_push_pop();
    logic [31:0] v;
    int n;
    push(0, 2'b01, 1, 16'h0A0A, 0, 0);
    @(negedge clk);
    set_ev(0, 2'b10, 0, 16'h0B0B, 0, 0);
    reg_addr = A_DESC; reg_wr = 1;
    @(negedge clk);
    ev_valid = 0; reg_wr = 0;
    rd(A_DESC, v); chk("R10 push+pop head", v, exp_desc(0, 2'b10, 0, 16'h0B0B, 0));
    wr(A_DESC, 0);
    rd(A_DESC, v); chk("R10 push+pop count", v, 32'h0);
    for (int i = 0; i < 16; i++) push(0, 0, 1, 16'(i), 0, 0);
    @(negedge clk);
    set_ev(0, 2'b11, 1, 16'hF00D, 0, 0);
    reg_addr = A_DATA; reg_wr = 1;
    @(negedge clk);
    ev_valid = 0; reg_wr = 0;
    n = 0;
    for (int i = 0; i < 20; i++) begin
      rd(A_DESC, v);
      if (v[31]) begin
        n++;
        if (n == 16) chk("R10 full push+pop tail", v, exp_desc(0, 2'b11, 1, 16'hF00D, 0));
        wr(A_DESC, 0);
      end
    end
    chk("R10 full push+pop depth", 32'(n), 32'd16);
  endtask

  task automatic t_endpoint();
    logic [31:0] v;
    push(0, 2'b01, 0, 16'h4242, 0, 0);
    @(negedge clk); root_mode = 0;
    rd(A_DESC, v); chk("R11 endpoint desc zero", v, 32'h0);
    rd(A_DATA, v); chk("R11 endpoint data zero", v, 32'h0);
    wr(A_DESC, 0);
    @(negedge clk); root_mode = 1;
    rd(A_DESC, v); chk("R11 endpoint write kept head", v, exp_desc(0, 2'b01, 0, 16'h4242, 0));
  endtask

  task automatic t_reset_clears();
    logic [31:0] v;
    push(0, 2'b00, 1, 16'h9999, 0, 0);
    do_reset();
    rd(A_DESC, v); chk("R12 reset empties queue", v, 32'h0);
    chk("R12 reset clears overflow", {31'h0, overflow}, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
    $finish;
  end

  initial begin
    do_reset();
    t_reset_state();
    t_line_events();
    t_msi();
    t_order_overflow();
    t_empty_pop();
    t_push_pop();
    t_endpoint();
    t_reset_clears();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule